// File: doc/BRIEF.md
# DRAM Geometry Probe and Pattern Tester

This block finds out how a DRAM module is organised by trying accesses on it through an access sequencer. The sequencer turns a flat byte address into row, column and bank strobes, using a working address width and a row/column mask that this block supplies. Detection searches downward over candidate address widths. For each width it runs an eight-byte write/read-back pattern check at the highest address that width can reach. The first width that passes is taken. The block then probes one address past the end of the first bank to see whether a second bank answers. It reports the width, the number of banks and the capacity in bytes, kilobytes and megabytes.

Detection runs by itself once after reset, as soon as the sequencer signals that its start-up refresh is complete. It can be repeated on a detect command. A separate test command runs the same pattern check at any address. It reports pass or fail and, on a fail, the pattern that failed and the byte that came back. Each operation ends with a one-cycle done pulse.

Top module: `dram_geo_probe`

## Requirements
- R1: A pattern check writes a byte and then reads it back at the same address, for each byte of the fixed sequence 0xF0, 0x0F, 0xAA, 0x55, 0xC0, 0x30, 0x0C, 0x03, in that order.
- R2: A pattern check stops at the first byte whose read-back differs and issues no further accesses. It passes only if all eight bytes match. A failed test command reports the failing pattern in `fail_pat` and the byte read in `fail_got`. A passing test reports 0 in both.
- R3: Detection tries widths 12, 11, 10 and 9 in that order. Each check uses address 2^(2w)-1, where w is the candidate width. The search stops at the first width that passes.
- R4: While width w is being tried, `mem_width` equals w and `mem_mask` equals 2^w-1.
- R5: If no candidate width passes, detection ends with `det_err`=1 and `geo_bits`, `geo_banks` and `cap_bytes` all 0.
- R6: After a width passes, the address one above the tested top address (2^(2w)) is checked. A pass gives `geo_banks`=2 and a fail gives `geo_banks`=1. `det_err` is 0.
- R7: `cap_bytes` = 2^(2w) x 4 x banks, `cap_kb` = cap_bytes>>10 and `cap_mb` = cap_bytes>>20.
- R8: After reset, one detection starts automatically on the first cycle in which `seq_ready` is 1. Nothing starts while `seq_ready` is 0, and no further automatic run follows.
- R9: `done` is high for exactly one cycle at the end of each operation. Detection results change only when a detection completes, and test results change only when a test completes.
- R10: Commands arriving while `busy` is 1 are ignored. If detect and test are requested in the same idle cycle, detection runs.
- R11: The block holds `mem_req` high, and keeps `mem_addr`, `mem_we` and `mem_wdata` stable, until the sequencer returns `mem_ack`. Read data is taken in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_ready | input | 1 | Sequencer finished its start-up refresh |
| cmd_detect | input | 1 | Start a detection (one-cycle pulse) |
| cmd_test | input | 1 | Start a pattern test at `test_addr` |
| test_addr | input | 25 | Byte address for the test command |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| det_err | output | 1 | Last detection found no working width |
| geo_bits | output | 4 | Detected address width |
| geo_banks | output | 2 | Detected bank count |
| cap_bytes | output | 28 | Capacity in bytes |
| cap_kb | output | 18 | Capacity in kilobytes |
| cap_mb | output | 8 | Capacity in megabytes |
| test_pass | output | 1 | Last test passed |
| fail_pat | output | 8 | Pattern that failed in the last test |
| fail_got | output | 8 | Byte read back when the last test failed |
| mem_req | output | 1 | Access request to the sequencer |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 25 | Access byte address |
| mem_wdata | output | 8 | Write data |
| mem_width | output | 4 | Working address width for row/column split |
| mem_mask | output | 12 | Row/column mask for the working width |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |

## Verification
A behavioural module model answers only where its real row/column width and bank count reach. Detection is therefore tried on modules with 12, 10 and 9 real bits, with one and two banks, and on an 8-bit module that no candidate fits. Together these separate a correct downward search from an early stop, a wrong top address and a wrong bank probe. The test command is tried at a healthy address, at an address with a stuck-low data bit, and at an address in an absent bank. These three cases distinguish a full eight-pattern pass from an early exit on the second pattern and from an exit on the first. Command collisions and busy-time commands show which operation actually ran.

// File: rtl/dram_geo_probe.sv
module dram_geo_probe #(
  parameter int AW_MAX = 12,
  parameter int AW_MIN = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seq_ready,
  input  logic                  cmd_detect,
  input  logic                  cmd_test,
  input  logic [2*AW_MAX:0]     test_addr,
  output logic                  busy,
  output logic                  done,
  output logic                  det_err,
  output logic [$clog2(AW_MAX+1)-1:0] geo_bits,
  output logic [1:0]            geo_banks,
  output logic [2*AW_MAX+3:0]   cap_bytes,
  output logic [2*AW_MAX-7:0]   cap_kb,
  output logic [2*AW_MAX-17:0]  cap_mb,
  output logic                  test_pass,
  output logic [7:0]            fail_pat,
  output logic [7:0]            fail_got,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [2*AW_MAX:0]     mem_addr,
  output logic [7:0]            mem_wdata,
  output logic [$clog2(AW_MAX+1)-1:0] mem_width,
  output logic [AW_MAX-1:0]     mem_mask,
  input  logic                  mem_ack,
  input  logic [7:0]            mem_rdata
);
  localparam int ADDR_W = 2*AW_MAX + 1;
  localparam int WB     = $clog2(AW_MAX+1);
  localparam int CAP_W  = 2*AW_MAX + 4;
  localparam int SH_W   = WB + 2;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} state_t;
  typedef enum logic [1:0] {OP_WID, OP_BANK, OP_TEST} op_t;

  state_t state;
  op_t    op;
  logic [2:0]        pidx;
  logic [WB-1:0]     cur_w;
  logic [ADDR_W-1:0] cur_addr;
  logic              auto_pend;
  logic              rd_ok;
  logic [AW_MAX:0]   mask_full;
  logic [SH_W-1:0]   cap_sh;

  function automatic logic [7:0] pat_at(input logic [2:0] i);
    case (i)
      3'd0: pat_at = 8'hF0;
      3'd1: pat_at = 8'h0F;
      3'd2: pat_at = 8'hAA;
      3'd3: pat_at = 8'h55;
      3'd4: pat_at = 8'hC0;
      3'd5: pat_at = 8'h30;
      3'd6: pat_at = 8'h0C;
      default: pat_at = 8'h03;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] top_of(input logic [WB-1:0] w);
    top_of = (ADDR_W'(1) << {w, 1'b0}) - ADDR_W'(1);
  endfunction

  assign busy      = state != S_IDLE;
  assign mem_req   = busy;
  assign mem_we    = state == S_WR;
  assign mem_addr  = cur_addr;
  assign mem_wdata = pat_at(pidx);
  assign mem_width = cur_w;
  assign mask_full = ((AW_MAX+1)'(1) << cur_w) - (AW_MAX+1)'(1);
  assign mem_mask  = mask_full[AW_MAX-1:0];
  assign rd_ok     = mem_rdata == mem_wdata;
  assign cap_sh    = {1'b0, cur_w, 1'b0} + (rd_ok ? SH_W'(3) : SH_W'(2));
  assign cap_kb    = cap_bytes[CAP_W-1:10];
  assign cap_mb    = cap_bytes[CAP_W-1:20];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op        <= OP_WID;
      pidx      <= '0;
      cur_w     <= WB'(AW_MAX);
      cur_addr  <= '0;
      auto_pend <= 1'b1;
      done      <= 1'b0;
      det_err   <= 1'b0;
      geo_bits  <= '0;
      geo_banks <= '0;
      cap_bytes <= '0;
      test_pass <= 1'b0;
      fail_pat  <= '0;
      fail_got  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_detect || (auto_pend && seq_ready)) begin
            auto_pend <= 1'b0;
            op        <= OP_WID;
            cur_w     <= WB'(AW_MAX);
            cur_addr  <= top_of(WB'(AW_MAX));
            pidx      <= '0;
            state     <= S_WR;
          end else if (cmd_test) begin
            op       <= OP_TEST;
            cur_addr <= test_addr;
            pidx     <= '0;
            state    <= S_WR;
          end
        end
        S_WR: if (mem_ack) state <= S_RD;
        S_RD: begin
          if (mem_ack) begin
            if (rd_ok && pidx != 3'd7) begin
              pidx  <= pidx + 3'd1;
              state <= S_WR;
            end else begin
              pidx <= '0;
              case (op)
                OP_TEST: begin
                  test_pass <= rd_ok;
                  fail_pat  <= rd_ok ? 8'h00 : mem_wdata;
                  fail_got  <= rd_ok ? 8'h00 : mem_rdata;
                  done      <= 1'b1;
                  state     <= S_IDLE;
                end
                OP_WID: begin
                  if (rd_ok) begin
                    op       <= OP_BANK;
                    cur_addr <= cur_addr + ADDR_W'(1);
                    state    <= S_WR;
                  end else if (cur_w == WB'(AW_MIN)) begin
                    det_err   <= 1'b1;
                    geo_bits  <= '0;
                    geo_banks <= '0;
                    cap_bytes <= '0;
                    done      <= 1'b1;
                    state     <= S_IDLE;
                  end else begin
                    cur_w    <= cur_w - WB'(1);
                    cur_addr <= top_of(cur_w - WB'(1));
                    state    <= S_WR;
                  end
                end
                default: begin
                  det_err   <= 1'b0;
                  geo_bits  <= cur_w;
                  geo_banks <= rd_ok ? 2'd2 : 2'd1;
                  cap_bytes <= CAP_W'(1) << cap_sh;
                  done      <= 1'b1;
                  state     <= S_IDLE;
                end
              endcase
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_first_pat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_we && mem_wdata == 8'hF0));

  p_width_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_width <= WB'(AW_MAX) && mem_width >= WB'(AW_MIN)));

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && det_err) |-> (geo_banks == 2'd0 && cap_bytes == '0 && geo_bits == '0));

  p_no_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

endmodule

// File: tb/dram_geo_probe_tb.sv
module dram_geo_probe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_ready = 1'b0;
  logic        cmd_detect = 1'b0;
  logic        cmd_test = 1'b0;
  logic [24:0] test_addr = '0;
  logic        busy, done, det_err, test_pass;
  logic [3:0]  geo_bits, mem_width;
  logic [1:0]  geo_banks;
  logic [27:0] cap_bytes;
  logic [17:0] cap_kb;
  logic [7:0]  cap_mb, fail_pat, fail_got, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [24:0] mem_addr;
  logic [11:0] mem_mask;

  always #4 clk = ~clk;

  dram_geo_probe u_dut (
    .clk(clk), .rst_n(rst_n), .seq_ready(seq_ready), .cmd_detect(cmd_detect),
    .cmd_test(cmd_test), .test_addr(test_addr), .busy(busy), .done(done),
    .det_err(det_err), .geo_bits(geo_bits), .geo_banks(geo_banks),
    .cap_bytes(cap_bytes), .cap_kb(cap_kb), .cap_mb(cap_mb),
    .test_pass(test_pass), .fail_pat(fail_pat), .fail_got(fail_got),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_width(mem_width), .mem_mask(mem_mask),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int nchk = 0;
  int nfail = 0;
  int ndone = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural module model behind a sequencer
  int          phys_n = 12;
  int          phys_banks = 2;
  bit          fault_en = 0;
  logic [24:0] fault_a = '0;
  logic [7:0]  store [logic [31:0]];
  logic [7:0]  wlog_d [$];
  logic [24:0] wlog_a [$];
  logic [11:0] wlog_m [$];
  int          cnt = 0;
  int          hs_bad = 0;
  logic [24:0] hs_addr;
  logic        hs_we;
  logic [7:0]  hs_wd;
  logic [31:0] m_row, m_col, m_key;
  logic        m_bank, m_here;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      cnt       <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (cnt == 0) begin
          hs_addr = mem_addr; hs_we = mem_we; hs_wd = mem_wdata;
        end else if (hs_addr !== mem_addr || hs_we !== mem_we || hs_wd !== mem_wdata) begin
          hs_bad++;
        end
        if (cnt == 2) begin
          cnt     <= 0;
          mem_ack <= 1'b1;
          m_row  = (32'(mem_addr) >> mem_width) & 32'(mem_mask);
          m_col  = 32'(mem_addr) & 32'(mem_mask);
          m_bank = (32'(mem_addr) >> (2*mem_width)) != 0;
          m_here = (m_row < (32'd1 << phys_n)) && (m_col < (32'd1 << phys_n)) &&
                   (!m_bank || phys_banks == 2);
          m_key  = {7'd0, m_bank, m_row[11:0], m_col[11:0]};
          if (mem_we) begin
            wlog_d.push_back(mem_wdata);
            wlog_a.push_back(mem_addr);
            wlog_m.push_back(mem_mask);
            if (m_here) store[m_key] = mem_wdata;
          end else begin
            if (m_here && store.exists(m_key)) mem_rdata <= (fault_en && mem_addr == fault_a) ?
                                                 (store[m_key] & 8'hFD) : store[m_key];
            else mem_rdata <= 8'h00;
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  // scoreboard
  typedef struct {
    bit          is_test;
    logic        err;
    logic [3:0]  bits;
    logic [1:0]  banks;
    logic [63:0] cap;
    logic        pass;
    logic [7:0]  pat;
    logic [7:0]  got;
  } exp_t;
  exp_t exp_q [$];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && done) begin
      ndone++;
      chk("R9 done single cycle", prev_done, 1'b0);
      if (exp_q.size() == 0) begin
        chk("R10 unexpected operation end", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_test) begin
          chk("R2 test_pass", test_pass, e.pass);
          chk("R2 fail_pat", fail_pat, e.pat);
          chk("R2 fail_got", fail_got, e.got);
        end else begin
          chk("R5 det_err", det_err, e.err);
          chk("R3 geo_bits", geo_bits, e.bits);
          chk("R6 geo_banks", geo_banks, e.banks);
          chk("R7 cap_bytes", cap_bytes, e.cap);
          chk("R7 cap_kb", cap_kb, e.cap >> 10);
          chk("R7 cap_mb", cap_mb, e.cap >> 20);
        end
      end
    end
    prev_done = done;
  end

  task automatic set_model(input int n, input int b);
    phys_n = n; phys_banks = b; fault_en = 0;
    store.delete();
    wlog_d.delete(); wlog_a.delete(); wlog_m.delete();
  endtask

  task automatic push_detect(input int n, input int b);
    exp_t e;
    e.is_test = 0; e.pass = 0; e.pat = 0; e.got = 0;
    if (n >= 9 && n <= 12) begin
      e.err = 0; e.bits = 4'(n); e.banks = 2'(b);
      e.cap = (64'd1 << (2*n)) * 4 * b;
    end else begin
      e.err = 1; e.bits = 0; e.banks = 0; e.cap = 0;
    end
    exp_q.push_back(e);
  endtask

  task automatic push_test(input logic p, input logic [7:0] pt, input logic [7:0] gt);
    exp_t e;
    e.is_test = 1; e.err = 0; e.bits = 0; e.banks = 0; e.cap = 0;
    e.pass = p; e.pat = pt; e.got = gt;
    exp_q.push_back(e);
  endtask

  task automatic wait_done();
    int start;
    start = ndone;
    while (ndone == start) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_detect(input int n, input int b);
    set_model(n, b);
    push_detect(n, b);
    @(negedge clk); cmd_detect = 1'b1;
    @(negedge clk); cmd_detect = 1'b0;
    wait_done();
  endtask

  task automatic run_test(input logic [24:0] a, input logic p,
                          input logic [7:0] pt, input logic [7:0] gt);
    wlog_d.delete(); wlog_a.delete(); wlog_m.delete();
    push_test(p, pt, gt);
    @(negedge clk); test_addr = a; cmd_test = 1'b1;
    @(negedge clk); cmd_test = 1'b0;
    wait_done();
  endtask

  logic [7:0] pats [8] = '{8'hF0, 8'h0F, 8'hAA, 8'h55, 8'hC0, 8'h30, 8'h0C, 8'h03};

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int d0;
    set_model(12, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 idle before seq_ready", busy, 1'b0);
    chk("R8 no done before seq_ready", ndone, 0);
    chk("R9 reset det_err", det_err, 1'b0);
    chk("R9 reset geo_banks", geo_banks, 2'd0);

    // R8 automatic detection
    push_detect(12, 2);
    seq_ready = 1'b1;
    wait_done();
    repeat (30) @(negedge clk);
    chk("R8 single automatic run", ndone, 1);
    chk("R1 first write byte", wlog_d[0], 8'hF0);

    // R3 R4 R6 search on a 10-bit single-bank module
    run_detect(10, 1);
    chk("R3 write count", wlog_a.size(), 11);
    chk("R3 addr w12", wlog_a[0], 25'h0FF_FFFF);
    chk("R4 mask w12", wlog_m[0], 12'hFFF);
    chk("R3 addr w11", wlog_a[1], 25'h03F_FFFF);
    chk("R4 mask w11", wlog_m[1], 12'h7FF);
    chk("R3 addr w10", wlog_a[2], 25'h00F_FFFF);
    chk("R4 mask w10", wlog_m[2], 12'h3FF);
    chk("R6 bank probe addr", wlog_a[10], 25'h010_0000);

    // R1 R2 tests on the 10-bit module
    run_test(25'h01234, 1'b1, 8'h00, 8'h00);
    chk("R1 write count pass", wlog_d.size(), 8);
    for (int i = 0; i < 8; i++) chk("R1 pattern order", wlog_d[i], pats[i]);
    fault_en = 1; fault_a = 25'h05678;
    run_test(25'h05678, 1'b0, 8'h0F, 8'h0D);
    chk("R2 stop after second pattern", wlog_d.size(), 2);
    fault_en = 0;
    run_test(25'h100005, 1'b0, 8'hF0, 8'h00);
    chk("R2 stop after first pattern", wlog_d.size(), 1);
    chk("R9 detect results held", geo_bits, 4'd10);
    chk("R9 detect banks held", geo_banks, 2'd1);

    // R10 busy-time command ignored
    d0 = ndone;
    push_test(1'b1, 8'h00, 8'h00);
    @(negedge clk); test_addr = 25'h00777; cmd_test = 1'b1;
    @(negedge clk); cmd_test = 1'b0;
    repeat (3) @(negedge clk);
    cmd_detect = 1'b1;
    @(negedge clk); cmd_detect = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    chk("R10 busy command ignored", ndone - d0, 1);
    chk("R9 test results held", geo_bits, 4'd10);

    // R10 priority of detect over test
    set_model(9, 2);
    push_detect(9, 2);
    @(negedge clk); cmd_detect = 1'b1; cmd_test = 1'b1; test_addr = 25'h00010;
    @(negedge clk); cmd_detect = 1'b0; cmd_test = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R9 test results kept across detect", test_pass, 1'b1);

    run_detect(8, 1);
    run_detect(12, 1);

    chk("R11 handshake stable", hs_bad, 0);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule